// File: doc/BRIEF.md
# Bit-Serial Register Adder

This block adds two unsigned operands held in two shift registers while spending only one full adder on the arithmetic. Each clock, both registers shift right by one place. The full adder combines the two bits that leave the registers with a stored carry. The sum bit enters the top of the first register, and the bit that leaves the second register goes back into the second register's top. After one pass of register-width clocks, the first register holds the sum and the second register holds its operand again.

While the block is idle, software-free serial loading is available. Either register can be filled one bit per clock from a shared external data bit. The first bit shifted in ends up as the least significant bit. A start pulse launches an add. The block then reports a one-cycle completion pulse and keeps the final carry-out on a flag until the next add begins. A small controller with a bit counter sequences the pass through explicit shift, select and clear lines.

Top module: `bitser_add`

## Requirements
- R1: While rst_n is low at a clock edge, both registers clear to zero, and carry_o, busy_o and done_o go low.
- R2: While idle, each clock with load_a_i high and start_i low shifts register A right by one place with ser_din_i entering bit WIDTH-1. After WIDTH such clocks, the first bit driven sits in bit 0.
- R3: Register B loads the same way through load_b_i, and loading one register leaves the other register unchanged.
- R4: A clock edge with start_i high while idle raises busy_o and clears the carry. It is followed by exactly WIDTH shifting clocks, after which busy_o falls.
- R5: When an add completes, reg_a_o equals (A + B) modulo 2^WIDTH, computed from the operand values present at start.
- R6: When an add completes, reg_b_o equals its value at start.
- R7: carry_o equals bit WIDTH of A + B after completion and holds that value through idle cycles and serial loads until the next start.
- R8: done_o is high for exactly one cycle, the cycle right after the last shift, which is also the first cycle with busy_o low.
- R9: start_i asserted while busy is ignored: completion timing and results are those of the add already running.
- R10: load_a_i and load_b_i asserted while busy have no effect on the sum, on register B or on the timing.
- R11: If start_i and a load select are high in the same idle cycle, the add starts and the load bit is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Launch an add when idle |
| ser_din_i | input | 1 | External serial data bit for loading |
| load_a_i | input | 1 | Shift ser_din_i into register A when idle |
| load_b_i | input | 1 | Shift ser_din_i into register B when idle |
| busy_o | output | 1 | Add in progress |
| done_o | output | 1 | One-cycle completion pulse |
| carry_o | output | 1 | Carry out of the most significant bit of the last add |
| reg_a_o | output | WIDTH | Parallel contents of register A (sum after an add) |
| reg_b_o | output | WIDTH | Parallel contents of register B |

## Verification
The bench builds the block with its default WIDTH of 8, so the bit counter wraps at its full 3-bit range and a carry can ripple through all eight serial steps. With 8-bit operands, the vector rows can include all-ones plus one and all-ones plus all-ones, which exercise a carry into every bit position and the carry-out flag. The rows also cover alternating patterns that produce no carry at all. Directed cases stress the idle/busy boundary: start raised again mid-add, loads mid-add, start and load raised together, and reset asserted during a pass.

// File: rtl/bsa_pkg.sv
// Shared types for the bit-serial adder.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package bsa_pkg;

    // Controller state: idle (loading allowed) or running an add.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } bsa_state_e;

    // Control lines driven from the controller into the datapath.
    typedef struct packed {
        logic shift_a;   // shift register A right by one place
        logic shift_b;   // shift register B right by one place
        logic sel_a;     // 1: external bit into A, 0: adder sum into A
        logic sel_b;     // 1: external bit into B, 0: B's own lsb into B
        logic clr_carry; // clear the carry flip-flop
        logic clr_cnt;   // clear the bit counter
    } bsa_ctl_t;

endpackage

// File: rtl/bsa_shift_reg.sv
// Right-shifting register with a two-way input select on its top bit.
// With sel high the external bit enters, otherwise the internal bit does.
// Assumes: WIDTH >= 2; synchronous active-low reset.
module bsa_shift_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             sel,
    input  logic             din_ext,
    input  logic             din_int,
    output logic [WIDTH-1:0] q,
    output logic             lsb
);

    logic msb_in;

    // Select the bit that enters at the top.
    always_comb msb_in = sel ? din_ext : din_int;

    // Hold or shift right by one place.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (shift_en)
            q <= {msb_in, q[WIDTH-1:1]};
    end

    assign lsb = q[0];

    // Contents stay put on every cycle without a shift (R10, R3).
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(q));

    // A shift moves the former upper bits down one place (R2).
    p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> q[WIDTH-2:0] == $past(q[WIDTH-1:1]));

endmodule

// File: rtl/bsa_bit_alu.sv
// One-bit full adder with its carry flip-flop.
// The carry-in is the stored carry. The carry-out is captured on each enabled clock.
// Assumes: clr takes priority over en.
module bsa_bit_alu (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic a_bit,
    input  logic b_bit,
    output logic sum_o,
    output logic carry_q_o
);

    logic cout;

    // Full-adder sum and carry from the two operand bits and the stored carry.
    always_comb begin
        sum_o = a_bit ^ b_bit ^ carry_q_o;
        cout  = (a_bit & b_bit) | (carry_q_o & (a_bit ^ b_bit));
    end

    // Carry storage: cleared before the first bit, updated on each step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            carry_q_o <= 1'b0;
        else if (clr)
            carry_q_o <= 1'b0;
        else if (en)
            carry_q_o <= cout;
    end

    // Carry is zero in the cycle after a clear (R4).
    p_carry_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !carry_q_o);

    // With neither clear nor step, the carry is held (R7).
    p_carry_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !en) |=> $stable(carry_q_o));

endmodule

// File: rtl/bsa_ctrl.sv
// Sequencer for the serial add. Waits for start, clears the carry and counter,
// then shifts both registers WIDTH times and returns to idle with a done pulse.
// While idle, it steers the input selects to the external bit for loading.
// Assumes: WIDTH >= 2; start while running is ignored.
module bsa_ctrl
    import bsa_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start_i,
    input  logic     load_a_i,
    input  logic     load_b_i,
    output bsa_ctl_t ctl_o,
    output logic     busy_o,
    output logic     done_o
);

    localparam int CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

    bsa_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic             go;
    logic             last_step;

    // Start is taken only when idle; the final step is at the last count.
    always_comb begin
        go        = (state == ST_IDLE) && start_i;
        last_step = (state == ST_RUN) && (cnt == LAST);
    end

    // Decode control lines for the datapath.
    always_comb begin
        ctl_o.sel_a     = (state == ST_IDLE);
        ctl_o.sel_b     = (state == ST_IDLE);
        ctl_o.shift_a   = (state == ST_RUN) || ((state == ST_IDLE) && load_a_i && !start_i);
        ctl_o.shift_b   = (state == ST_RUN) || ((state == ST_IDLE) && load_b_i && !start_i);
        ctl_o.clr_carry = go;
        ctl_o.clr_cnt   = go;
    end

    // State register: idle to run on start, run to idle after the last step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else if (go)
            state <= ST_RUN;
        else if (last_step)
            state <= ST_IDLE;
    end

    // Bit counter: cleared at start, advanced on each running step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (ctl_o.clr_cnt)
            cnt <= '0;
        else if (state == ST_RUN)
            cnt <= cnt + 1'b1;
    end

    // Completion pulse registered from the last step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done_o <= 1'b0;
        else
            done_o <= last_step;
    end

    assign busy_o = (state == ST_RUN);

    // Done lasts exactly one cycle (R8).
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // Done appears only with busy low (R8).
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // A run begins at count zero (R4).
    p_cnt_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> cnt == '0);

    // Before the last count, the run continues whatever start does (R9).
    p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && cnt != LAST) |=> (busy_o && cnt == $past(cnt) + 1'b1));

    // After the last count, the block is idle with done set (R4).
    p_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && cnt == LAST) |=> (!busy_o && done_o));

endmodule

// File: rtl/bitser_add.sv
// Bit-serial adder top. Two WIDTH-bit shift registers feed one full adder.
// Sum bits refill A from the top, and B rotates back into itself.
// Assumes: operands are loaded serially, least significant bit first, while idle.
module bitser_add #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             ser_din_i,
    input  logic             load_a_i,
    input  logic             load_b_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             carry_o,
    output logic [WIDTH-1:0] reg_a_o,
    output logic [WIDTH-1:0] reg_b_o
);

    import bsa_pkg::*;

    bsa_ctl_t ctl;
    logic     a_lsb;
    logic     b_lsb;
    logic     sum_bit;

    bsa_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .load_a_i (load_a_i),
        .load_b_i (load_b_i),
        .ctl_o    (ctl),
        .busy_o   (busy_o),
        .done_o   (done_o)
    );

    bsa_shift_reg #(.WIDTH(WIDTH)) u_reg_a (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (ctl.shift_a),
        .sel      (ctl.sel_a),
        .din_ext  (ser_din_i),
        .din_int  (sum_bit),
        .q        (reg_a_o),
        .lsb      (a_lsb)
    );

    bsa_shift_reg #(.WIDTH(WIDTH)) u_reg_b (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (ctl.shift_b),
        .sel      (ctl.sel_b),
        .din_ext  (ser_din_i),
        .din_int  (b_lsb),
        .q        (reg_b_o),
        .lsb      (b_lsb)
    );

    bsa_bit_alu u_alu (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (ctl.clr_carry),
        .en        (busy_o),
        .a_bit     (a_lsb),
        .b_bit     (b_lsb),
        .sum_o     (sum_bit),
        .carry_q_o (carry_o)
    );

    // While running, B's bit leaving the bottom reappears at the top (R6).
    p_b_rotate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> reg_b_o[WIDTH-1] == $past(reg_b_o[0]));

    // A start accepted together with a load leaves A untouched that cycle (R11).
    p_start_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && load_a_i) |=> $stable(reg_a_o));

    // Carry is clear on the first running cycle (R4).
    p_carry_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> !carry_o);

endmodule

// File: tb/bitser_add_bench.sv
module bitser_add_bench;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         ser_din_i = 1'b0;
    logic         load_a_i = 1'b0;
    logic         load_b_i = 1'b0;
    logic         busy_o;
    logic         done_o;
    logic         carry_o;
    logic [W-1:0] reg_a_o;
    logic [W-1:0] reg_b_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    bitser_add #(.WIDTH(W)) u_bitser_add (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .ser_din_i (ser_din_i),
        .load_a_i  (load_a_i),
        .load_b_i  (load_b_i),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .carry_o   (carry_o),
        .reg_a_o   (reg_a_o),
        .reg_b_o   (reg_b_o)
    );

    // Operand pairs {a, b}.
    localparam logic [15:0] VEC [8] = '{
        16'h0000, 16'hFF01, 16'hFFFF, 16'hA55A,
        16'h8080, 16'h7F01, 16'h3CC3, 16'h1234
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Serially load a register, least significant bit first. Entered and left at a negedge.
    task automatic load_reg(input bit to_b, input logic [W-1:0] v);
        for (int i = 0; i < W; i++) begin
            ser_din_i = v[i];
            load_a_i  = !to_b;
            load_b_i  = to_b;
            @(negedge clk);
        end
        load_a_i = 1'b0;
        load_b_i = 1'b0;
    endtask

    // Start an add, check the busy window and the done pulse, and return at the done cycle.
    task automatic run_add(input string req);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R4 busy after start", busy_o, 1);
        check(carry_o == 1'b0, "R4 carry cleared", carry_o, 0);
        for (int k = 1; k < W; k++) begin
            @(negedge clk);
            if (done_o !== 1'b0 || busy_o !== 1'b1)
                check(1'b0, req, {done_o, busy_o}, 1);
        end
        @(negedge clk);
        check(done_o == 1'b1 && busy_o == 1'b0, "R8 done with busy low", {done_o, busy_o}, 2);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [W:0] s;
        repeat (3) @(negedge clk);
        // R1: reset state.
        check(reg_a_o == 0 && reg_b_o == 0, "R1 regs", {reg_a_o, reg_b_o}, 0);
        check(!busy_o && !done_o && !carry_o, "R1 flags", {busy_o, done_o, carry_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector walk: R2, R3, R5, R6, R7, R8.
        foreach (VEC[i]) begin
            logic [W-1:0] a;
            logic [W-1:0] b;
            a = VEC[i][15:8];
            b = VEC[i][7:0];
            load_reg(1'b0, a);
            check(reg_a_o == a, "R2 load A", reg_a_o, a);
            load_reg(1'b1, b);
            check(reg_b_o == b && reg_a_o == a, "R3 load B keeps A", {reg_a_o, reg_b_o}, {a, b});
            run_add("R4 busy window");
            s = {1'b0, a} + {1'b0, b};
            check(reg_a_o == s[W-1:0], "R5 sum", reg_a_o, s[W-1:0]);
            check(reg_b_o == b, "R6 B kept", reg_b_o, b);
            check(carry_o == s[W], "R7 carry", carry_o, s[W]);
            @(negedge clk);
            check(done_o == 1'b0, "R8 single pulse", done_o, 0);
        end

        // R7: carry held through idle and loads (last add left carry 0; make it 1).
        load_reg(1'b0, 8'hF0);
        load_reg(1'b1, 8'h20);
        run_add("R4 busy window");
        check(carry_o == 1'b1 && reg_a_o == 8'h10, "R7 carry set", {carry_o, reg_a_o}, 9'h110);
        repeat (3) @(negedge clk);
        load_reg(1'b0, 8'h01);
        check(carry_o == 1'b1, "R7 carry held", carry_o, 1);

        // R9 and R10: start and loads while busy.
        load_reg(1'b1, 8'h02);
        start_i = 1'b1;
        @(negedge clk);
        check(busy_o == 1'b1, "R4 busy", busy_o, 1);
        for (int k = 1; k < W; k++) begin
            start_i   = (k == 3);
            load_a_i  = (k >= 4);
            load_b_i  = (k >= 4);
            ser_din_i = 1'b1;
            @(negedge clk);
            if (done_o !== 1'b0 || busy_o !== 1'b1)
                check(1'b0, "R9 timing kept", {done_o, busy_o}, 1);
        end
        start_i  = 1'b0;
        load_a_i = 1'b0;
        load_b_i = 1'b0;
        @(negedge clk);
        check(done_o == 1'b1, "R9 done on time", done_o, 1);
        check(reg_a_o == 8'h03 && reg_b_o == 8'h02, "R10 result kept",
              {reg_a_o, reg_b_o}, 16'h0302);
        @(negedge clk);
        check(busy_o == 1'b0, "R9 no second run", busy_o, 0);

        // R11: start with load in the same idle cycle.
        ser_din_i = 1'b1;
        load_a_i  = 1'b1;
        start_i   = 1'b1;
        @(negedge clk);
        load_a_i = 1'b0;
        start_i  = 1'b0;
        check(busy_o == 1'b1 && reg_a_o == 8'h03, "R11 start wins", {busy_o, reg_a_o}, 9'h103);
        repeat (W) @(negedge clk);
        check(reg_a_o == 8'h05, "R11 sum without load bit", reg_a_o, 8'h05);

        // R1: reset during a run.
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(!busy_o && reg_a_o == 0 && reg_b_o == 0 && !carry_o, "R1 mid-run reset",
              {busy_o, carry_o, reg_a_o, reg_b_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule